// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block sits between one processor and the source side of an interrupt system. It holds four pieces of state: the processor's current priority, the priority of a pending inter-processor interrupt (IPI), a single pending slot, and a resend flag. The pending slot holds a source identifier and its priority. Priorities are 8 bits, and a smaller value is more favored. The block raises an interrupt request line whenever the pending slot holds something more favored than the processor priority. IPIs and external interrupts share the one slot. Because of this, every priority change can displace the pending source, reject it back to the source side, or trigger a resend request.

Software drives a single-cycle command port. It has four operations: accept, set processor priority, set IPI priority, and end-of-interrupt. A source controller presents interrupts on the offer port. That controller receives three kinds of feedback: take/refuse pulses for each offer, reject pulses carrying the displaced source identifier, and resend pulses.

The pending slot behaves as a three-state machine, and the state is the kind of occupant: SLOT_EMPTY (identifier 0, priority 0xFF), SLOT_IPI (identifier 2) or SLOT_EXT (any other identifier). The transitions are named after the event that causes them:
- ACCEPT empties the slot.
- SETIPI moves it to SLOT_IPI.
- SETPRIO-raise empties it.
- SETPRIO-lower and EOI can promote to SLOT_IPI.
- OFFER-take moves it to SLOT_EXT.

Top module: `irq_presenter`

## Requirements
- R1: Reset sets the processor priority to 0x00, the IPI priority to 0xFF, the pending priority to 0xFF, the pending identifier to 0 and the resend flag to 0. After reset, irq_out is low and every pulse output is low.
- R2: irq_out is high exactly when the pending identifier is nonzero and the pending priority is strictly below the processor priority. It reflects the state after the most recent clock edge.
- R3: Accept (cmd_op 0) returns acc_word, with bits 31:24 holding the processor priority from before the command and bits 23:0 holding the pending identifier. If the slot was occupied, the processor priority takes the pending priority and the slot empties. If the slot was empty, nothing changes.
- R4: Set-IPI-priority (cmd_op 2, value in cmd_data[7:0]) always stores the value. If the value is below the processor priority, the slot takes the value and identifier 2. A non-IPI occupant is reported rejected when the value is at most the old pending priority.
- R5: Set-IPI-priority with a value above both the old IPI priority and the processor priority reports the resend flag on resend_valid and clears the flag.
- R6: Set-processor-priority (cmd_op 1, value in cmd_data[7:0]) with a larger value loads it. If the IPI priority is below the new value and no greater than the pending priority, the IPI becomes the occupant. The resend flag is reported on resend_valid and cleared.
- R7: Set-processor-priority with a value equal to the current one changes nothing and produces no pulse.
- R8: Set-processor-priority with a smaller value loads it. If the new value is at most the pending priority, the slot empties and the occupant is reported rejected, unless it is the IPI or the slot was empty.
- R9: End-of-interrupt (cmd_op 3) applies cmd_data[31:24] under the R6 rules, whether or not the value is larger. When cmd_data[23:0] is neither 0 nor 2 and eoi_level is high, that identifier is reported on the reject outputs.
- R10: When no command is valid, an offer with a nonzero identifier is taken only if its priority is below both the processor priority and the pending priority. A taken offer pulses offer_ack, becomes the occupant, and a displaced non-IPI occupant is rejected.
- R11: An offer that is not taken, including any offer made in the same cycle as a command, pulses offer_nak and sets the resend flag. This happens after any clearing by that command.
- R12: Every pulse (acc_valid, rej_valid, resend_valid, offer_ack, offer_nak) is registered. It is high for exactly the one cycle after the edge that sampled its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 accept, 1 set processor priority, 2 set IPI priority, 3 end-of-interrupt |
| cmd_data | input | 32 | Priority in bits 7:0, or the end-of-interrupt word |
| eoi_level | input | 1 | Level of the completed source is still asserted |
| offer_valid | input | 1 | Source controller offers an interrupt |
| offer_src | input | 24 | Offered source identifier |
| offer_prio | input | 8 | Offered priority |
| irq_out | output | 1 | Interrupt request to the processor |
| acc_valid | output | 1 | Accept result valid |
| acc_word | output | 32 | Accept result: priority in bits 31:24, identifier in bits 23:0 |
| rej_valid | output | 1 | Reject or re-delivery report |
| rej_src | output | 24 | Rejected source identifier |
| resend_valid | output | 1 | Resend request to the source side |
| offer_ack | output | 1 | Offer taken |
| offer_nak | output | 1 | Offer refused |

## Verification
The bench builds the block with its default widths: 8-bit priorities, 24-bit identifiers and IPI identifier 2. The random priority picker is biased toward the values currently held: the processor priority, the pending priority, the IPI priority, 0x00 and 0xFF. This makes the equal-value and off-by-one comparisons of R4 to R10 common rather than rare. The identifier picker favors 2, 0 and the current occupant, which brings the IPI exemptions, empty-slot accepts and self-displacement within reach.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    parameter int PRIO_W = 8;
    parameter int SRC_W  = 24;
    localparam int WORD_W = PRIO_W + SRC_W;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [SRC_W-1:0]  src_t;

    localparam prio_t PRIO_NONE = '1;
    localparam src_t  SRC_NONE  = '0;
    parameter  src_t  SRC_IPI   = src_t'(2);

    typedef enum logic [1:0] {
        OP_ACCEPT  = 2'd0,
        OP_SETPRIO = 2'd1,
        OP_SETIPI  = 2'd2,
        OP_EOI     = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SLOT_EMPTY,
        SLOT_IPI,
        SLOT_EXT
    } slot_e;

    typedef struct packed {
        prio_t cur_prio;
        prio_t ipi_prio;
        prio_t pend_prio;
        src_t  pend_src;
        logic  resend;
    } ctl_state_t;

    typedef struct packed {
        logic              acc_v;
        logic [WORD_W-1:0] acc_word;
        logic              rej_v;
        src_t              rej_src;
        logic              rsnd_v;
        logic              ack_v;
        logic              nak_v;
    } evt_t;

    function automatic slot_e slot_of(src_t s);
        if (s == SRC_NONE)     return SLOT_EMPTY;
        else if (s == SRC_IPI) return SLOT_IPI;
        else                   return SLOT_EXT;
    endfunction
endpackage

// File: rtl/ipc_engine.sv
module ipc_engine
    import ipc_pkg::*;
(
    input  ctl_state_t         cur,
    input  logic               cmd_valid,
    input  op_e                cmd_op,
    input  logic [WORD_W-1:0]  cmd_data,
    input  logic               eoi_level,
    input  logic               offer_valid,
    input  src_t               offer_src,
    input  prio_t              offer_prio,
    output ctl_state_t         nxt,
    output evt_t               ev
);
    prio_t arg;
    prio_t eoi_prio;
    src_t  eoi_src;
    prio_t new_prio;
    slot_e slot_cur;
    logic  ipi_wins;
    logic  offer_fits;

    always_comb begin
        arg       = cmd_data[PRIO_W-1:0];
        eoi_prio  = cmd_data[WORD_W-1:SRC_W];
        eoi_src   = cmd_data[SRC_W-1:0];
        new_prio  = (cmd_op == OP_EOI) ? eoi_prio : arg;
        slot_cur  = slot_of(cur.pend_src);
        ipi_wins  = (cur.ipi_prio < new_prio) && (cur.ipi_prio <= cur.pend_prio);
        offer_fits = (offer_src != SRC_NONE) && (offer_prio < cur.cur_prio)
                     && (offer_prio < cur.pend_prio);
        nxt = cur;
        ev  = '0;

        if (cmd_valid) begin
            unique case (cmd_op)
                OP_ACCEPT: begin
                    ev.acc_v    = 1'b1;
                    ev.acc_word = {cur.cur_prio, cur.pend_src};
                    if (slot_cur != SLOT_EMPTY) begin
                        nxt.cur_prio  = cur.pend_prio;
                        nxt.pend_prio = PRIO_NONE;
                        nxt.pend_src  = SRC_NONE;
                    end
                end
                OP_SETIPI: begin
                    nxt.ipi_prio = arg;
                    if (arg < cur.cur_prio) begin
                        if (arg <= cur.pend_prio && slot_cur == SLOT_EXT) begin
                            ev.rej_v   = 1'b1;
                            ev.rej_src = cur.pend_src;
                        end
                        nxt.pend_prio = arg;
                        nxt.pend_src  = SRC_IPI;
                    end
                    if (arg > cur.ipi_prio && arg > cur.cur_prio) begin
                        ev.rsnd_v  = cur.resend;
                        nxt.resend = 1'b0;
                    end
                end
                OP_SETPRIO, OP_EOI: begin
                    if (cmd_op == OP_EOI || arg > cur.cur_prio) begin
                        nxt.cur_prio = new_prio;
                        if (ipi_wins) begin
                            nxt.pend_prio = cur.ipi_prio;
                            nxt.pend_src  = SRC_IPI;
                        end
                        ev.rsnd_v  = cur.resend;
                        nxt.resend = 1'b0;
                        if (cmd_op == OP_EOI && eoi_level
                            && slot_of(eoi_src) == SLOT_EXT) begin
                            ev.rej_v   = 1'b1;
                            ev.rej_src = eoi_src;
                        end
                    end else if (arg < cur.cur_prio) begin
                        nxt.cur_prio = arg;
                        if (arg <= cur.pend_prio) begin
                            nxt.pend_prio = PRIO_NONE;
                            nxt.pend_src  = SRC_NONE;
                            if (slot_cur == SLOT_EXT) begin
                                ev.rej_v   = 1'b1;
                                ev.rej_src = cur.pend_src;
                            end
                        end
                    end
                end
            endcase
            if (offer_valid) begin
                ev.nak_v   = 1'b1;
                nxt.resend = 1'b1;
            end
        end else if (offer_valid) begin
            if (offer_fits) begin
                ev.ack_v = 1'b1;
                if (slot_cur == SLOT_EXT) begin
                    ev.rej_v   = 1'b1;
                    ev.rej_src = cur.pend_src;
                end
                nxt.pend_prio = offer_prio;
                nxt.pend_src  = offer_src;
            end else begin
                ev.nak_v   = 1'b1;
                nxt.resend = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ipc_store.sv
module ipc_store
    import ipc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ctl_state_t nxt,
    input  evt_t       ev,
    output ctl_state_t st,
    output evt_t       ev_q,
    output slot_e      slot_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st.cur_prio  <= '0;
            st.ipi_prio  <= PRIO_NONE;
            st.pend_prio <= PRIO_NONE;
            st.pend_src  <= SRC_NONE;
            st.resend    <= 1'b0;
            ev_q         <= '0;
            slot_q       <= SLOT_EMPTY;
        end else begin
            st     <= nxt;
            ev_q   <= ev;
            slot_q <= slot_of(nxt.pend_src);
        end
    end

    p_resend_had_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_q.rsnd_v |-> $past(st.resend));

    p_empty_slot_prio_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == SLOT_EMPTY) |-> (st.pend_prio == PRIO_NONE));
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
    import ipc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic              eoi_level,
    input  logic              offer_valid,
    input  logic [SRC_W-1:0]  offer_src,
    input  logic [PRIO_W-1:0] offer_prio,
    output logic              irq_out,
    output logic              acc_valid,
    output logic [WORD_W-1:0] acc_word,
    output logic              rej_valid,
    output logic [SRC_W-1:0]  rej_src,
    output logic              resend_valid,
    output logic              offer_ack,
    output logic              offer_nak
);
    ctl_state_t st;
    ctl_state_t nxt;
    evt_t       ev;
    evt_t       ev_q;
    slot_e      slot_q;
    op_e        op;

    assign op = op_e'(cmd_op);

    ipc_engine u_engine (
        .cur         (st),
        .cmd_valid   (cmd_valid),
        .cmd_op      (op),
        .cmd_data    (cmd_data),
        .eoi_level   (eoi_level),
        .offer_valid (offer_valid),
        .offer_src   (offer_src),
        .offer_prio  (offer_prio),
        .nxt         (nxt),
        .ev          (ev)
    );

    ipc_store u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .nxt    (nxt),
        .ev     (ev),
        .st     (st),
        .ev_q   (ev_q),
        .slot_q (slot_q)
    );

    always_comb begin
        irq_out      = (slot_q != SLOT_EMPTY) && (st.pend_prio < st.cur_prio);
        acc_valid    = ev_q.acc_v;
        acc_word     = ev_q.acc_word;
        rej_valid    = ev_q.rej_v;
        rej_src      = ev_q.rej_src;
        resend_valid = ev_q.rsnd_v;
        offer_ack    = ev_q.ack_v;
        offer_nak    = ev_q.nak_v;
    end

    p_accept_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_ACCEPT && st.pend_src != SRC_NONE && !offer_valid)
        |=> (st.pend_src == SRC_NONE && st.pend_prio == PRIO_NONE && acc_valid));

    p_ipi_takes_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_SETIPI && cmd_data[PRIO_W-1:0] < st.cur_prio)
        |=> (st.pend_src == SRC_IPI && st.pend_prio == $past(cmd_data[PRIO_W-1:0])));

    p_lower_clears_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_SETPRIO && cmd_data[PRIO_W-1:0] > st.cur_prio && !offer_valid)
        |=> !st.resend);

    p_same_prio_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_SETPRIO && cmd_data[PRIO_W-1:0] == st.cur_prio && !offer_valid)
        |=> ($stable(st) && !rej_valid && !resend_valid));

    p_reject_never_ipi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid |-> (rej_src != SRC_IPI && rej_src != SRC_NONE));

    p_offer_single_answer_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({offer_ack, offer_nak}));

    p_refused_sets_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        offer_nak |-> st.resend);

    p_pulse_one_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (offer_valid && !cmd_valid) |=> (offer_ack || offer_nak));
endmodule

// File: tb/sim_irq_presenter.sv
`timescale 1ns/1ps
module sim_irq_presenter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [31:0] cmd_data = '0;
    logic        eoi_level = 1'b0;
    logic        offer_valid = 1'b0;
    logic [23:0] offer_src = '0;
    logic [7:0]  offer_prio = '0;
    logic        irq_out, acc_valid, rej_valid, resend_valid, offer_ack, offer_nak;
    logic [31:0] acc_word;
    logic [23:0] rej_src;

    int n_chk = 0;
    int n_err = 0;

    // model state
    logic [7:0]  m_cur, m_ipi, m_pend;
    logic [23:0] m_src;
    logic        m_rs;
    // expected events
    logic        e_acc, e_rej, e_rs, e_ack, e_nak;
    logic [31:0] e_word;
    logic [23:0] e_rsrc;
    string       m_tag;

    always #5 clk = ~clk;

    irq_presenter u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .eoi_level(eoi_level), .offer_valid(offer_valid),
        .offer_src(offer_src), .offer_prio(offer_prio), .irq_out(irq_out),
        .acc_valid(acc_valid), .acc_word(acc_word), .rej_valid(rej_valid),
        .rej_src(rej_src), .resend_valid(resend_valid), .offer_ack(offer_ack),
        .offer_nak(offer_nak)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cur = 8'h00; m_ipi = 8'hFF; m_pend = 8'hFF; m_src = '0; m_rs = 1'b0;
    endtask

    function automatic logic is_ext(input logic [23:0] s);
        return (s != 24'd0) && (s != 24'd2);
    endfunction

    task automatic model_step(input logic v, input logic [1:0] op, input logic [31:0] d,
                              input logic lvl, input logic ov, input logic [23:0] os,
                              input logic [7:0] opr);
        logic [7:0] a;
        logic [7:0] np;
        a = d[7:0];
        e_acc = 0; e_rej = 0; e_rs = 0; e_ack = 0; e_nak = 0; e_word = '0; e_rsrc = '0;
        m_tag = "R10";
        if (v) begin
            if (op == 2'd0) begin
                m_tag = "R3 R12";
                e_acc = 1; e_word = {m_cur, m_src};
                if (m_src != 0) begin m_cur = m_pend; m_pend = 8'hFF; m_src = 0; end
            end else if (op == 2'd2) begin
                m_tag = "R4";
                if (a < m_cur) begin
                    if (a <= m_pend && is_ext(m_src)) begin e_rej = 1; e_rsrc = m_src; end
                    m_pend = a; m_src = 24'd2;
                end
                if (a > m_ipi && a > m_cur) begin m_tag = "R5"; e_rs = m_rs; m_rs = 0; end
                m_ipi = a;
            end else if (op == 2'd3 || a > m_cur) begin
                m_tag = (op == 2'd3) ? "R9" : "R6";
                np = (op == 2'd3) ? d[31:24] : a;
                m_cur = np;
                if (m_ipi < np && m_ipi <= m_pend) begin m_pend = m_ipi; m_src = 24'd2; end
                e_rs = m_rs; m_rs = 0;
                if (op == 2'd3 && lvl && is_ext(d[23:0])) begin e_rej = 1; e_rsrc = d[23:0]; end
            end else if (a == m_cur) begin
                m_tag = "R7";
            end else begin
                m_tag = "R8";
                m_cur = a;
                if (a <= m_pend) begin
                    if (is_ext(m_src)) begin e_rej = 1; e_rsrc = m_src; end
                    m_pend = 8'hFF; m_src = 0;
                end
            end
            if (ov) begin e_nak = 1; m_rs = 1; end
        end else if (ov) begin
            if (os != 0 && opr < m_cur && opr < m_pend) begin
                e_ack = 1;
                if (is_ext(m_src)) begin e_rej = 1; e_rsrc = m_src; end
                m_pend = opr; m_src = os;
            end else begin
                m_tag = "R11"; e_nak = 1; m_rs = 1;
            end
        end
    endtask

    task automatic step(input logic v, input logic [1:0] op, input logic [31:0] d,
                        input logic lvl, input logic ov, input logic [23:0] os,
                        input logic [7:0] opr);
        logic e_irq;
        cmd_valid = v; cmd_op = op; cmd_data = d; eoi_level = lvl;
        offer_valid = ov; offer_src = os; offer_prio = opr;
        model_step(v, op, d, lvl, ov, os, opr);
        @(posedge clk);
        #1;
        e_irq = (m_src != 0) && (m_pend < m_cur);
        check(irq_out == e_irq, "R2", {"irq after ", m_tag}, 64'(irq_out), 64'(e_irq));
        check(acc_valid == e_acc, m_tag, "acc_valid R12", 64'(acc_valid), 64'(e_acc));
        if (e_acc) check(acc_word == e_word, m_tag, "acc_word R3", 64'(acc_word), 64'(e_word));
        check(rej_valid == e_rej, m_tag, "rej_valid", 64'(rej_valid), 64'(e_rej));
        if (e_rej) check(rej_src == e_rsrc, m_tag, "rej_src", 64'(rej_src), 64'(e_rsrc));
        check(resend_valid == e_rs, m_tag, "resend_valid", 64'(resend_valid), 64'(e_rs));
        check(offer_ack == e_ack, m_tag, "offer_ack", 64'(offer_ack), 64'(e_ack));
        check(offer_nak == e_nak, m_tag, "offer_nak R11", 64'(offer_nak), 64'(e_nak));
    endtask

    function automatic logic [7:0] rprio();
        case ($urandom_range(0, 7))
            0: return 8'h00;
            1: return 8'hFF;
            2: return m_cur;
            3: return m_pend;
            4: return m_ipi;
            5: return m_cur + 8'd1;
            6: return m_cur - 8'd1;
            default: return 8'($urandom_range(0, 255));
        endcase
    endfunction

    function automatic logic [23:0] rsrc();
        case ($urandom_range(0, 5))
            0: return 24'd2;
            1: return 24'd0;
            2: return m_src;
            default: return 24'($urandom());
        endcase
    endfunction

    initial begin
        #2000000;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240517));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: state right after reset
        check(irq_out == 0, "R1", "irq after reset", 64'(irq_out), 64'd0);
        check({acc_valid, rej_valid, resend_valid, offer_ack, offer_nak} == 5'd0,
              "R1", "pulses after reset", 64'({acc_valid, rej_valid, resend_valid, offer_ack, offer_nak}), 64'd0);
        // R1/R3: accept of empty slot shows reset priority 0 and identifier 0
        step(1, 2'd0, 32'd0, 0, 0, 0, 0);
        check(acc_word == 32'h0000_0000, "R1", "reset accept word", 64'(acc_word), 64'd0);
        // directed walk
        step(1, 2'd1, 32'hFF, 0, 0, 0, 0);          // R6 lower to FF
        step(0, 2'd0, 0, 0, 1, 24'h000123, 8'h40);  // R10 take
        step(1, 2'd0, 0, 0, 0, 0, 0);               // R3 accept 0x123
        step(0, 2'd0, 0, 0, 1, 24'h000456, 8'h30);  // R10 take
        step(1, 2'd2, 32'h10, 0, 0, 0, 0);          // R4 IPI displaces 0x456
        step(0, 2'd0, 0, 0, 1, 24'h000055, 8'h20);  // R11 refused
        step(1, 2'd2, 32'h90, 0, 0, 0, 0);          // R5 resend
        step(1, 2'd1, 32'h40, 0, 0, 0, 0);          // R7 same
        step(1, 2'd1, 32'h05, 0, 0, 0, 0);          // R8 raise, IPI no reject
        step(1, 2'd1, 32'hC0, 0, 0, 0, 0);          // R6 lower, IPI promoted
        step(1, 2'd3, 32'hFF00_0777, 1, 0, 0, 0);   // R9 re-delivery
        step(1, 2'd3, 32'hFF00_0002, 1, 0, 0, 0);   // R9 IPI no action
        step(1, 2'd1, 32'h80, 0, 1, 24'h9, 8'h01);  // R11 offer during command
        for (int i = 0; i < 6000; i++) begin
            int k;
            k = $urandom_range(0, 9);
            if (k < 4)
                step(0, 2'd0, 0, 0, 1, rsrc(), rprio());
            else
                step(1, 2'($urandom_range(0, 3)),
                     {rprio(), rsrc()} | {24'd0, ($urandom_range(0, 1) == 1) ? rprio() : 8'd0},
                     1'($urandom_range(0, 1)), (k == 9), rsrc(), rprio());
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule